// File: doc/BRIEF.md
# CAN Fault Confinement and Bus-Off Recovery Unit

This block holds the fault-confinement state of a CAN node. It keeps the transmit and receive error counters, which a protocol engine moves with one-cycle increment and decrement strobes. From those counters it derives a warning flag and a bus-off flag. It owns the initialization bit, which the CPU writes, and it produces a bus-participation enable that tells the frame logic when the node may take part in traffic.

When the transmit error counter would go above 255, the node goes bus-off. The block then forces the initialization bit to 1 and drops participation in the same cycle. Nothing further happens until the CPU writes 0 to the initialization bit. From that point the block counts runs of eleven recessive sample points, taken from a per-bit-time sample strobe and the sampled bus level. Each completed run is reported as a Bit0Error last-error-code update, and also as a status event when status events are enabled. After the 128th run, both counters return to zero and the node rejoins the bus.

Outside bus-off, clearing the initialization bit makes the node wait for one run of eleven recessive samples before it joins. Setting the bit takes the node off the bus.

Top module: `can_fault_confine`

## Requirements
- R1: After reset, init_bit is 1, bus_off, err_warn, bus_on, lec_upd and status_evt are 0, lec_code is 0, and both error counters are 0.
- R2: err_warn is 1 whenever either error counter is at least 96, and it returns to 0 once both counters are below 96.
- R3: An increment strobe that takes the transmit error counter from 255 to 256 sets bus_off and init_bit and clears bus_on at the same clock edge that updates the counter.
- R4: While bus-off with init_bit still at 1, recessive samples produce no lec_upd. The recovery sequence starts only when the CPU writes init_bit to 0. bus_off stays 1 throughout recovery.
- R5: A recovery run is 11 consecutive sample strobes with bus_rx=1 (recessive). A sample with bus_rx=0 (dominant) restarts the current run but keeps the count of completed runs. Cycles without sample_en neither extend nor break a run.
- R6: Each completed recovery run gives a one-cycle lec_upd pulse with lec_code=5 (Bit0Error). status_evt pulses in the same cycle only when status_irq_en is 1.
- R7: The 128th completed run clears both error counters and bus_off at the same edge, sets bus_on, and re-evaluates err_warn from the cleared counters.
- R8: CPU writes to init_bit during recovery are ignored. init_bit stays 0, and the partial run and the completed-run count are kept.
- R9: Outside bus-off, a CPU write of 0 to init_bit makes the node wait for 11 consecutive recessive samples before bus_on rises. A write of 1 returns init_bit to 1 and clears bus_on.
- R10: Counter strobes change the counters only while bus_on is 1. An increment and a decrement of the same counter in one cycle leave that counter unchanged.
- R11: Each error counter saturates at 511 on increment and at 0 on decrement. It never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_err_inc | input | 1 | Transmit error counter increment strobe |
| tx_err_dec | input | 1 | Transmit error counter decrement strobe |
| rx_err_inc | input | 1 | Receive error counter increment strobe |
| rx_err_dec | input | 1 | Receive error counter decrement strobe |
| sample_en | input | 1 | One-cycle strobe at each bit-time sample point |
| bus_rx | input | 1 | Sampled bus level, 1 = recessive |
| cpu_init_wr | input | 1 | CPU write strobe for the initialization bit |
| cpu_init_val | input | 1 | Value written to the initialization bit |
| status_irq_en | input | 1 | Enables status events for recovery runs |
| tx_err_cnt | output | 9 | Transmit error counter |
| rx_err_cnt | output | 9 | Receive error counter |
| err_warn | output | 1 | Error warning flag |
| bus_off | output | 1 | Bus-off flag |
| init_bit | output | 1 | Initialization bit |
| bus_on | output | 1 | Node may take part in bus traffic |
| lec_upd | output | 1 | Last-error-code update pulse |
| lec_code | output | 3 | Last error code, 5 after a recovery run |
| status_evt | output | 1 | Status event pulse for a recovery run |

## Verification
The checker watches several properties on every cycle. Bus-off entry must set init_bit and must follow a transmit increment. An exit from bus-off must land on zero counters with the node rejoining. Every lec_upd must carry code 5 and follow a recessive sample. status_evt may only occur together with lec_upd. The counters must stay frozen while the node is off the bus and not bus-off, and an increment at the top value must not wrap. Other properties depend on counting over long windows: that exactly 128 runs are needed, that a dominant sample restarts only the partial run, that ignored init writes neither shorten nor restart recovery, and that a join needs exactly eleven recessive samples. Only the bench's scenarios, compared against the cycle model, can show these.

// File: rtl/can_fc_pkg.sv
// Shared types for the CAN fault-confinement unit.
// Assumes: one state machine owns the node's participation mode.
package can_fc_pkg;

    // Node operating mode; flags at the top level are decoded from it.
    typedef enum logic [2:0] {
        FC_CONF   = 3'd0,   // initialization bit set by CPU
        FC_SYNC   = 3'd1,   // waiting for one recessive run before joining
        FC_ACTIVE = 3'd2,   // taking part in bus traffic
        FC_BOFF   = 3'd3,   // bus-off, waiting for CPU to clear init
        FC_RECOV  = 3'd4    // bus-off recovery in progress
    } fc_state_e;

    localparam logic [2:0] LEC_NONE = 3'd0;
    localparam logic [2:0] LEC_BIT0 = 3'd5;

    // Counter index map: bit 0 transmit, bit 1 receive.
    localparam int         FC_NCNT  = 2;
    localparam logic [1:0] BOFF_SRC = 2'b01;   // counters able to force bus-off

endpackage

// File: rtl/fc_sat_ctr.sv
// Saturating up/down error counter.
// Moves only when enabled. Simultaneous up and down cancel. Never wraps.
// Assumes: clear has priority over any strobe.
module fc_sat_ctr #(
    parameter int W     = 9,
    parameter int LIMIT = 255
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         inc,
    input  logic         dec,
    input  logic         clr,
    output logic [W-1:0] cnt,
    output logic         nxt_over
);
    localparam logic [W-1:0] TOP = '1;
    localparam logic [W-1:0] LIM = W'(LIMIT);

    logic [W-1:0] cnt_nxt;

    // Next value with saturation at both ends.
    always_comb begin
        cnt_nxt = cnt;
        if (en && inc && !dec && cnt != TOP)
            cnt_nxt = cnt + 1'b1;
        else if (en && dec && !inc && cnt != '0)
            cnt_nxt = cnt - 1'b1;
    end

    assign nxt_over = cnt_nxt > LIM;

    // Counter register.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else          cnt <= cnt_nxt;
    end
endmodule

// File: rtl/fc_run_detect.sv
// Counts consecutive recessive sample points into runs of RUN_LEN.
// While tallying, it also counts completed runs toward RUNS.
// Assumes: armed drops whenever the node leaves sync or recovery.
module fc_run_detect #(
    parameter int RUN_LEN = 11,
    parameter int RUNS    = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic tally,
    input  logic sample_en,
    input  logic bus_rx,
    output logic run_done,
    output logic last_run
);
    localparam int BW = $clog2(RUN_LEN);
    localparam int NW = (RUNS > 2) ? $clog2(RUNS) : 1;

    logic [BW-1:0] bit_cnt;
    logic [NW-1:0] run_cnt;

    assign run_done = armed && sample_en && bus_rx && (bit_cnt == BW'(RUN_LEN - 1));
    assign last_run = run_done && tally && (run_cnt == NW'(RUNS - 1));

    // Recessive-bit counter; a dominant sample restarts the run.
    always_ff @(posedge clk) begin
        if (!rst_n || !armed)  bit_cnt <= '0;
        else if (sample_en) begin
            if (!bus_rx || run_done) bit_cnt <= '0;
            else                     bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // Completed-run counter, live only during recovery.
    always_ff @(posedge clk) begin
        if (!rst_n || !tally) run_cnt <= '0;
        else if (run_done)    run_cnt <= run_cnt + 1'b1;
    end
endmodule

// File: rtl/fc_ctrl.sv
// Participation state machine and last-error-code reporting.
// Assumes: boff_hit is the next-cycle over-limit test of the transmit counter.
module fc_ctrl
    import can_fc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cpu_init_wr,
    input  logic      cpu_init_val,
    input  logic      sie,
    input  logic      boff_hit,
    input  logic      run_done,
    input  logic      last_run,
    output fc_state_e state,
    output logic      cnt_clr,
    output logic      lec_upd,
    output logic [2:0] lec_code,
    output logic      status_evt
);
    fc_state_e state_nxt;
    logic      recov_run;

    assign recov_run = run_done && (state == FC_RECOV);
    assign cnt_clr   = last_run && (state == FC_RECOV);

    // Next-state selection; bus-off entry outranks any CPU write.
    always_comb begin
        state_nxt = state;
        unique case (state)
            FC_CONF:   if (cpu_init_wr && !cpu_init_val) state_nxt = FC_SYNC;
            FC_SYNC:   if (cpu_init_wr && cpu_init_val)  state_nxt = FC_CONF;
                       else if (run_done)                state_nxt = FC_ACTIVE;
            FC_ACTIVE: if (boff_hit)                     state_nxt = FC_BOFF;
                       else if (cpu_init_wr && cpu_init_val) state_nxt = FC_CONF;
            FC_BOFF:   if (cpu_init_wr && !cpu_init_val) state_nxt = FC_RECOV;
            FC_RECOV:  if (cnt_clr)                      state_nxt = FC_ACTIVE;
            default:                                     state_nxt = FC_CONF;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= FC_CONF;
        else        state <= state_nxt;
    end

    // Run report pulses and sticky last error code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lec_upd    <= 1'b0;
            status_evt <= 1'b0;
            lec_code   <= LEC_NONE;
        end else begin
            lec_upd    <= recov_run;
            status_evt <= recov_run && sie;
            if (recov_run) lec_code <= LEC_BIT0;
        end
    end
endmodule

// File: rtl/can_fault_confine.sv
// Top level of the CAN fault-confinement unit.
// Holds the error counters, the participation FSM and the recessive-run detector.
// Assumes: strobes are one cycle wide and synchronous to clk.
module can_fault_confine
    import can_fc_pkg::*;
#(
    parameter int CNT_W      = 9,
    parameter int WARN_LIMIT = 96,
    parameter int BOFF_LIMIT = 255,
    parameter int RUN_LEN    = 11,
    parameter int RECOV_RUNS = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_err_inc,
    input  logic             tx_err_dec,
    input  logic             rx_err_inc,
    input  logic             rx_err_dec,
    input  logic             sample_en,
    input  logic             bus_rx,
    input  logic             cpu_init_wr,
    input  logic             cpu_init_val,
    input  logic             status_irq_en,
    output logic [CNT_W-1:0] tx_err_cnt,
    output logic [CNT_W-1:0] rx_err_cnt,
    output logic             err_warn,
    output logic             bus_off,
    output logic             init_bit,
    output logic             bus_on,
    output logic             lec_upd,
    output logic [2:0]       lec_code,
    output logic             status_evt
);
    localparam logic [CNT_W-1:0] WARN_TH = CNT_W'(WARN_LIMIT);

    fc_state_e          state;
    logic               cnt_clr, run_done, last_run, boff_hit;
    logic [FC_NCNT-1:0] inc_v, dec_v, over_v, warn_v;
    logic [CNT_W-1:0]   cnt_q [FC_NCNT];

    assign inc_v = {rx_err_inc, tx_err_inc};
    assign dec_v = {rx_err_dec, tx_err_dec};

    // One saturating counter per error direction.
    for (genvar g = 0; g < FC_NCNT; g++) begin : g_cnt
        fc_sat_ctr #(.W(CNT_W), .LIMIT(BOFF_LIMIT)) u_ctr (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (state == FC_ACTIVE),
            .inc      (inc_v[g]),
            .dec      (dec_v[g]),
            .clr      (cnt_clr),
            .cnt      (cnt_q[g]),
            .nxt_over (over_v[g])
        );
        assign warn_v[g] = cnt_q[g] >= WARN_TH;
    end

    assign boff_hit = |(over_v & BOFF_SRC);

    fc_run_detect #(.RUN_LEN(RUN_LEN), .RUNS(RECOV_RUNS)) u_run (
        .clk       (clk),
        .rst_n     (rst_n),
        .armed     ((state == FC_SYNC) || (state == FC_RECOV)),
        .tally     (state == FC_RECOV),
        .sample_en (sample_en),
        .bus_rx    (bus_rx),
        .run_done  (run_done),
        .last_run  (last_run)
    );

    fc_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_init_wr  (cpu_init_wr),
        .cpu_init_val (cpu_init_val),
        .sie          (status_irq_en),
        .boff_hit     (boff_hit),
        .run_done     (run_done),
        .last_run     (last_run),
        .state        (state),
        .cnt_clr      (cnt_clr),
        .lec_upd      (lec_upd),
        .lec_code     (lec_code),
        .status_evt   (status_evt)
    );

    assign tx_err_cnt = cnt_q[0];
    assign rx_err_cnt = cnt_q[1];
    assign err_warn   = |warn_v;
    assign bus_off    = (state == FC_BOFF) || (state == FC_RECOV);
    assign init_bit   = (state == FC_BOFF) || (state == FC_CONF);
    assign bus_on     = (state == FC_ACTIVE);
endmodule

// File: rtl/fc_confine_chk.sv
// Port-level property checker for can_fault_confine, bound below.
module fc_confine_chk #(
    parameter int CNT_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tx_err_inc,
    input logic             rx_err_inc,
    input logic             rx_err_dec,
    input logic             sample_en,
    input logic             bus_rx,
    input logic [CNT_W-1:0] tx_err_cnt,
    input logic [CNT_W-1:0] rx_err_cnt,
    input logic             bus_off,
    input logic             init_bit,
    input logic             bus_on,
    input logic             lec_upd,
    input logic [2:0]       lec_code,
    input logic             status_evt
);
    localparam logic [CNT_W-1:0] TOP = '1;

    // R3
    boff_sets_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_off) |-> init_bit && !bus_on);

    // R3
    boff_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_off) |-> $past(tx_err_inc));

    // R7
    recov_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_off) |-> (tx_err_cnt == '0) && (rx_err_cnt == '0) && bus_on && lec_upd);

    // R8
    recov_init_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_off && !init_bit) |=> !init_bit);

    // R6
    lec_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lec_upd |-> lec_code == 3'd5);

    // R6
    status_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_evt |-> lec_upd);

    // R5
    run_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lec_upd |-> $past(sample_en && bus_rx));

    // R9
    join_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_on) |-> $past(sample_en && bus_rx));

    // R10
    frozen_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_on && !bus_off) |=> $stable(tx_err_cnt) && $stable(rx_err_cnt));

    // R11
    rx_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_on && rx_err_cnt == TOP && rx_err_inc && !rx_err_dec) |=> rx_err_cnt == TOP);
endmodule

bind can_fault_confine fc_confine_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_err_inc (tx_err_inc),
    .rx_err_inc (rx_err_inc),
    .rx_err_dec (rx_err_dec),
    .sample_en  (sample_en),
    .bus_rx     (bus_rx),
    .tx_err_cnt (tx_err_cnt),
    .rx_err_cnt (rx_err_cnt),
    .bus_off    (bus_off),
    .init_bit   (init_bit),
    .bus_on     (bus_on),
    .lec_upd    (lec_upd),
    .lec_code   (lec_code),
    .status_evt (status_evt)
);

// File: tb/sim_can_fault_confine.sv
`timescale 1ns/1ps
// Bench: behavioural cycle model compared at every falling edge, plus directed checks.
module sim_can_fault_confine;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_err_inc = 0, tx_err_dec = 0, rx_err_inc = 0, rx_err_dec = 0;
    logic sample_en = 0, bus_rx = 0, cpu_init_wr = 0, cpu_init_val = 0, status_irq_en = 0;
    logic [8:0] tx_err_cnt, rx_err_cnt;
    logic err_warn, bus_off, init_bit, bus_on, lec_upd, status_evt;
    logic [2:0] lec_code;

    always #5 clk = ~clk;

    can_fault_confine u0 (.*);

    int n_chk = 0, n_bad = 0, lec_cnt = 0, sevt_cnt = 0;
    bit done = 0;

    // Model: mode 0 conf, 1 sync, 2 active, 3 bus-off, 4 recovery.
    int m_st, m_tec, m_rec, m_bit, m_runs, m_lec, nt, nr;
    bit m_lupd, m_sevt, m_done, m_last, m_armed;

    function automatic int step(int v, bit i, bit d);
        if (i && !d && v < 511) return v + 1;
        if (d && !i && v > 0) return v - 1;
        return v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_tec = 0; m_rec = 0; m_bit = 0; m_runs = 0;
            m_lec = 0; m_lupd = 0; m_sevt = 0;
        end else begin
            m_armed = (m_st == 1) || (m_st == 4);
            m_done  = m_armed && sample_en && bus_rx && (m_bit == 10);
            m_last  = m_done && (m_st == 4) && (m_runs == 127);
            nt = m_tec; nr = m_rec;
            if (m_st == 2) begin
                nt = step(m_tec, tx_err_inc, tx_err_dec);
                nr = step(m_rec, rx_err_inc, rx_err_dec);
            end
            m_lupd = m_done && (m_st == 4);
            m_sevt = m_lupd && status_irq_en;
            if (m_lupd) m_lec = 5;
            if (!m_armed) m_bit = 0;
            else if (sample_en) m_bit = (!bus_rx || m_done) ? 0 : m_bit + 1;
            if (m_st != 4) m_runs = 0;
            else if (m_done) m_runs++;
            case (m_st)
                0: if (cpu_init_wr && !cpu_init_val) m_st = 1;
                1: if (cpu_init_wr && cpu_init_val) m_st = 0; else if (m_done) m_st = 2;
                2: if (nt > 255) m_st = 3; else if (cpu_init_wr && cpu_init_val) m_st = 0;
                3: if (cpu_init_wr && !cpu_init_val) m_st = 4;
                default: if (m_last) m_st = 2;
            endcase
            if (m_last) begin nt = 0; nr = 0; end
            m_tec = nt; m_rec = nr;
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
        end
    endtask

    // Per-cycle comparison against the model.
    always @(negedge clk) if (rst_n && !done) begin
        chk("R2 err_warn", err_warn, (m_tec >= 96 || m_rec >= 96));
        chk("R10 tx_err_cnt", tx_err_cnt, m_tec);
        chk("R10 rx_err_cnt", rx_err_cnt, m_rec);
        chk("R3 bus_off", bus_off, (m_st == 3 || m_st == 4));
        chk("R4 init_bit", init_bit, (m_st == 0 || m_st == 3));
        chk("R9 bus_on", bus_on, (m_st == 2));
        chk("R6 lec_upd", lec_upd, m_lupd);
        chk("R6 lec_code", lec_code, m_lec);
        chk("R6 status_evt", status_evt, m_sevt);
    end

    // Pulse counters, sampled between edges.
    always @(posedge clk) begin
        #2;
        if (lec_upd) lec_cnt++;
        if (status_evt) sevt_cnt++;
    end

    task automatic cnt_pulse(bit ti, bit td, bit ri, bit rd, int n);
        for (int i = 0; i < n; i++) begin
            tx_err_inc = ti; tx_err_dec = td; rx_err_inc = ri; rx_err_dec = rd;
            @(negedge clk);
        end
        tx_err_inc = 0; tx_err_dec = 0; rx_err_inc = 0; rx_err_dec = 0;
    endtask

    task automatic samples(int n, bit lvl);
        for (int i = 0; i < n; i++) begin
            sample_en = 1; bus_rx = lvl;
            @(negedge clk);
        end
        sample_en = 0;
    endtask

    task automatic wr_init(bit v);
        cpu_init_wr = 1; cpu_init_val = v;
        @(negedge clk);
        cpu_init_wr = 0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 init_bit", init_bit, 1);
        chk("R1 bus_off", bus_off, 0);
        chk("R1 bus_on", bus_on, 0);
        chk("R1 err_warn", err_warn, 0);
        chk("R1 lec_code", lec_code, 0);
        chk("R1 counters", tx_err_cnt + rx_err_cnt, 0);
        // R10 strobes ignored while in configuration
        cnt_pulse(0, 0, 1, 0, 5);
        chk("R10 rx ignored off-bus", rx_err_cnt, 0);
        // R9 join after 11 recessive samples, dominant restarts
        wr_init(0);
        samples(10, 1);
        chk("R9 not joined after 10", bus_on, 0);
        samples(1, 0);
        samples(10, 1);
        chk("R9 dominant restarted wait", bus_on, 0);
        samples(1, 1);
        chk("R9 joined after 11", bus_on, 1);
        // R2 warning threshold
        cnt_pulse(0, 0, 1, 0, 95);
        chk("R2 warn at 95", err_warn, 0);
        cnt_pulse(0, 0, 1, 0, 1);
        chk("R2 warn at 96", err_warn, 1);
        cnt_pulse(0, 0, 1, 1, 3);
        chk("R10 inc+dec cancel", rx_err_cnt, 96);
        cnt_pulse(0, 0, 0, 1, 1);
        chk("R2 warn clears at 95", err_warn, 0);
        // R11 saturation both ends
        cnt_pulse(0, 0, 1, 0, 500);
        chk("R11 saturate top", rx_err_cnt, 511);
        cnt_pulse(0, 0, 0, 1, 520);
        chk("R11 saturate zero", rx_err_cnt, 0);
        // R3 bus-off entry
        cnt_pulse(0, 0, 1, 0, 100);
        cnt_pulse(1, 0, 0, 0, 255);
        chk("R3 no bus-off at 255", bus_off, 0);
        cnt_pulse(1, 0, 0, 0, 1);
        chk("R3 bus_off set", bus_off, 1);
        chk("R3 init forced", init_bit, 1);
        chk("R3 bus_on dropped", bus_on, 0);
        cnt_pulse(1, 0, 0, 1, 10);
        chk("R10 frozen tx", tx_err_cnt, 256);
        chk("R10 frozen rx", rx_err_cnt, 100);
        // R4 no recovery before CPU clear
        lec_cnt = 0; sevt_cnt = 0;
        samples(40, 1);
        chk("R4 no runs before clear", lec_cnt, 0);
        chk("R4 still init", init_bit, 1);
        wr_init(0);
        chk("R4 init cleared", init_bit, 0);
        chk("R4 still bus-off", bus_off, 1);
        // R6 reporting with status events on
        status_irq_en = 1;
        samples(11, 1);
        chk("R6 first run", lec_cnt, 1);
        chk("R6 code", lec_code, 5);
        chk("R6 status on", sevt_cnt, 1);
        // R5 dominant restarts only the partial run
        samples(6, 1);
        samples(1, 0);
        samples(10, 1);
        chk("R5 partial restarted", lec_cnt, 1);
        samples(1, 1);
        chk("R5 run kept", lec_cnt, 2);
        status_irq_en = 0;
        samples(11, 1);
        chk("R6 no status when off", sevt_cnt, 2);
        // R8 init writes during recovery ignored
        samples(5, 1);
        wr_init(1);
        chk("R8 init stays 0", init_bit, 0);
        wr_init(0);
        samples(6, 1);
        chk("R8 run not restarted", lec_cnt, 4);
        samples(11 * 123, 1);
        chk("R7 still bus-off at 127", bus_off, 1);
        samples(11, 1);
        // R7 recovery completion
        chk("R7 runs total", lec_cnt, 128);
        chk("R7 bus_off cleared", bus_off, 0);
        chk("R7 bus_on", bus_on, 1);
        chk("R7 tx cleared", tx_err_cnt, 0);
        chk("R7 rx cleared", rx_err_cnt, 0);
        chk("R7 warn re-evaluated", err_warn, 0);
        // R9 return to configuration
        wr_init(1);
        chk("R9 init set", init_bit, 1);
        chk("R9 off bus", bus_on, 0);
        cnt_pulse(0, 0, 1, 0, 3);
        chk("R10 ignored in conf", rx_err_cnt, 0);
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R7 watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end
endmodule